// File: doc/BRIEF.md
# Byte-Lane Parity Checker and Generator

This unit sits on a 36-bit data port that is cut into four 9-bit lanes. Each lane carries eight data bits with its parity bit on top. Words arriving on the port bus are checked against the parity sense chosen by a single odd/even input. If any lane is bad, an active-low error flag drops.

The same set of lane parity trees also produces parity for mailbox reads. While a mailbox read with generation is selected, the trees are steered to the mailbox word. The outgoing copy gets freshly computed parity bits, and the error flag is held inactive, because the trees are no longer looking at the bus. The mailbox contents themselves are never changed.

A separate path handles FIFO reads. The word read from memory can have its parity bits regenerated before it enters an output register that loads on the read clock edge. The generate-select and odd/even inputs are therefore sampled on that edge.

Top module: `lane_parity_unit`

## Requirements
- R1: Lane k (k = 0..3) holds data in bits 9k to 9k+7 and its parity bit in bit 9k+8. So the parity bits are 8, 17, 26 and 35.
- R2: With `odd_sel` = 1 a lane is valid when its nine bits hold an odd number of ones. With `odd_sel` = 0 it is valid when they hold an even number. The same sense is used for generation.
- R3: Outside a mailbox generate-read, `par_err_n` is 0 exactly when at least one lane of `bus_in` is invalid, and 1 otherwise. It is combinational.
- R4: A mailbox generate-read is selected when `cs_n`=0, `en`=1, `wr_rd`=0, `mbx_sel`=1 and `gen_en`=1. While it is selected, `par_err_n` is 1 whatever `bus_in` carries.
- R5: During a mailbox generate-read, `mbx_out` equals `mbx_word` with each parity bit replaced by the generated one. At all other times `mbx_out` equals `mbx_word`. Data bits are never altered.
- R6: On a rising `clk` edge with `fifo_rd_en`=1, `fifo_q` loads `fifo_rd_word`. If `gen_en` is 1 at that edge, the parity bits are replaced by parity generated with the `odd_sel` value at that edge.
- R7: With `fifo_rd_en`=0, `fifo_q` holds its value.
- R8: A synchronous `rst`=1 clears `fifo_q` to zero at the next rising edge, and it overrides a read.
- R9: When `gen_en`=1 but no mailbox read is selected (for example `cs_n`=1), checking of `bus_in` stays active as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| cs_n | input | 1 | Active-low port select |
| en | input | 1 | Port transfer enable |
| wr_rd | input | 1 | 1 = write, 0 = read |
| mbx_sel | input | 1 | Selects the mailbox instead of the FIFO |
| gen_en | input | 1 | Parity generation request for reads |
| bus_in | input | 36 | Incoming port bus, checked |
| mbx_word | input | 36 | Stored mailbox register contents |
| mbx_out | output | 36 | Mailbox word as driven out on a read |
| par_err_n | output | 1 | Active-low lane parity error flag |
| fifo_rd_en | input | 1 | FIFO read strobe for this edge |
| fifo_rd_word | input | 36 | Word read from FIFO memory |
| fifo_q | output | 36 | FIFO output register |

## Verification
On every cycle, the assertions check the following:
- The error flag stays high during a mailbox generate-read.
- Data bits pass unchanged through both the mailbox and FIFO paths.
- The output register holds when no read occurs.
- After a generating FIFO read, every lane of the register has the parity sampled at the edge.

Whether the flag drops for the right lanes, under single and multiple bit corruptions in each parity sense, can only be shown by the bench's sweeps against its reference functions. The same applies to the reset override and to checking that stays live while generation is requested without a mailbox read.

// File: rtl/lpar_pkg.sv
package lpar_pkg;
  // Which word the shared lane trees are looking at.
  typedef enum logic {
    TREE_BUS = 1'b0,
    TREE_MBX = 1'b1
  } tree_src_e;
endpackage

// File: rtl/lpar_lane.sv
// One lane tree: parity bit for DATA_W data bits in the chosen sense.
module lpar_lane #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              odd_sel,
  output logic              par_bit
);
  // Odd sense needs the inverse of the data XOR to make the total odd.
  assign par_bit = (^data) ^ odd_sel;
endmodule

// File: rtl/lpar_word.sv
// Replicates lane trees across a packed word of data-only bits.
module lpar_word #(
  parameter int LANES  = 4,
  parameter int DATA_W = 8
) (
  input  logic [LANES*DATA_W-1:0] data,
  input  logic                    odd_sel,
  output logic [LANES-1:0]        par
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lpar_lane #(.DATA_W(DATA_W)) u_lane (
      .data    (data[k*DATA_W +: DATA_W]),
      .odd_sel (odd_sel),
      .par_bit (par[k])
    );
  end
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit #(
  parameter int LANES  = 4,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           odd_sel,
  input  logic                           cs_n,
  input  logic                           en,
  input  logic                           wr_rd,
  input  logic                           mbx_sel,
  input  logic                           gen_en,
  input  logic [LANES*(DATA_W+1)-1:0]    bus_in,
  input  logic [LANES*(DATA_W+1)-1:0]    mbx_word,
  output logic [LANES*(DATA_W+1)-1:0]    mbx_out,
  output logic                           par_err_n,
  input  logic                           fifo_rd_en,
  input  logic [LANES*(DATA_W+1)-1:0]    fifo_rd_word,
  output logic [LANES*(DATA_W+1)-1:0]    fifo_q
);
  import lpar_pkg::*;

  localparam int LANE_W = DATA_W + 1;
  localparam int BUS_W  = LANES * LANE_W;
  localparam int PACK_W = LANES * DATA_W;

  logic              mbx_gen_rd;
  tree_src_e         tree_src;
  logic [BUS_W-1:0]  tree_word;
  logic [PACK_W-1:0] tree_data;
  logic [LANES-1:0]  tree_stored;
  logic [LANES-1:0]  tree_par;
  logic [LANES-1:0]  lane_bad;
  logic [BUS_W-1:0]  mbx_gen_word;

  logic [PACK_W-1:0] fifo_data;
  logic [LANES-1:0]  fifo_par;
  logic [BUS_W-1:0]  fifo_gen_word;
  logic [BUS_W-1:0]  fifo_next;

  // Shared trees are handed to the mailbox only for a generating mailbox read.
  assign mbx_gen_rd = !cs_n && en && !wr_rd && mbx_sel && gen_en;
  assign tree_src   = mbx_gen_rd ? TREE_MBX : TREE_BUS;
  assign tree_word  = (tree_src == TREE_MBX) ? mbx_word : bus_in;

  for (genvar k = 0; k < LANES; k++) begin : g_slice
    assign tree_data[k*DATA_W +: DATA_W] = tree_word[k*LANE_W +: DATA_W];
    assign tree_stored[k]                = tree_word[k*LANE_W + DATA_W];
    assign mbx_gen_word[k*LANE_W +: DATA_W] = mbx_word[k*LANE_W +: DATA_W];
    assign mbx_gen_word[k*LANE_W + DATA_W]  = tree_par[k];

    assign fifo_data[k*DATA_W +: DATA_W]     = fifo_rd_word[k*LANE_W +: DATA_W];
    assign fifo_gen_word[k*LANE_W +: DATA_W] = fifo_rd_word[k*LANE_W +: DATA_W];
    assign fifo_gen_word[k*LANE_W + DATA_W]  = fifo_par[k];
  end

  lpar_word #(.LANES(LANES), .DATA_W(DATA_W)) u_shared_trees (
    .data    (tree_data),
    .odd_sel (odd_sel),
    .par     (tree_par)
  );

  lpar_word #(.LANES(LANES), .DATA_W(DATA_W)) u_fifo_trees (
    .data    (fifo_data),
    .odd_sel (odd_sel),
    .par     (fifo_par)
  );

  // A lane fails when its stored parity bit differs from the recomputed one.
  assign lane_bad  = tree_par ^ tree_stored;
  assign par_err_n = mbx_gen_rd || !(|lane_bad);
  assign mbx_out   = mbx_gen_rd ? mbx_gen_word : mbx_word;

  assign fifo_next = gen_en ? fifo_gen_word : fifo_rd_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_q <= '0;
    end else if (fifo_rd_en) begin
      fifo_q <= fifo_next;
    end
  end
endmodule

// File: rtl/lane_parity_unit_chk.sv
module lane_parity_unit_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 8
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           odd_sel,
  input logic                           cs_n,
  input logic                           en,
  input logic                           wr_rd,
  input logic                           mbx_sel,
  input logic                           gen_en,
  input logic [LANES*(DATA_W+1)-1:0]    bus_in,
  input logic [LANES*(DATA_W+1)-1:0]    mbx_word,
  input logic [LANES*(DATA_W+1)-1:0]    mbx_out,
  input logic                           par_err_n,
  input logic                           fifo_rd_en,
  input logic [LANES*(DATA_W+1)-1:0]    fifo_rd_word,
  input logic [LANES*(DATA_W+1)-1:0]    fifo_q
);
  localparam int LANE_W = DATA_W + 1;

  // R4
  mbx_gen_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && en && !wr_rd && mbx_sel && gen_en) |-> par_err_n);

  // R7
  fifo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fifo_rd_en |=> $stable(fifo_q));

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    // R5
    mbx_data_keep_chk: assert property (@(posedge clk) disable iff (rst)
      mbx_out[k*LANE_W +: DATA_W] == mbx_word[k*LANE_W +: DATA_W]);

    // R6
    fifo_data_keep_chk: assert property (@(posedge clk) disable iff (rst)
      fifo_rd_en |=> fifo_q[k*LANE_W +: DATA_W] == $past(fifo_rd_word[k*LANE_W +: DATA_W]));

    // R6
    fifo_gen_sense_chk: assert property (@(posedge clk) disable iff (rst)
      (fifo_rd_en && gen_en) |=> (^fifo_q[k*LANE_W +: LANE_W]) == $past(odd_sel));
  end
endmodule

bind lane_parity_unit lane_parity_unit_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/lane_parity_unit_test.sv
module lane_parity_unit_test;
  localparam int LANES = 4;
  localparam int DW    = 8;
  localparam int LW    = DW + 1;
  localparam int BW    = LANES * LW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic odd_sel = 1'b0, cs_n = 1'b1, en = 1'b0, wr_rd = 1'b0, mbx_sel = 1'b0, gen_en = 1'b0;
  logic fifo_rd_en = 1'b0;
  logic [BW-1:0] bus_in = '0, mbx_word = '0, fifo_rd_word = '0;
  logic [BW-1:0] mbx_out, fifo_q;
  logic par_err_n;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  logic [BW-1:0] model_q = '0;

  always #10 clk = ~clk;

  lane_parity_unit #(.LANES(LANES), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .odd_sel(odd_sel), .cs_n(cs_n), .en(en), .wr_rd(wr_rd),
    .mbx_sel(mbx_sel), .gen_en(gen_en), .bus_in(bus_in), .mbx_word(mbx_word),
    .mbx_out(mbx_out), .par_err_n(par_err_n), .fifo_rd_en(fifo_rd_en),
    .fifo_rd_word(fifo_rd_word), .fifo_q(fifo_q)
  );

  // Reference (R1, R2): lane k at bits 9k..9k+8, parity on top.
  function automatic logic [BW-1:0] ref_gen(input logic [BW-1:0] w, input logic odd);
    logic [BW-1:0] r = w;
    for (int k = 0; k < LANES; k++) begin
      int n = $countones(w[k*LW +: DW]);
      r[k*LW + DW] = ((n % 2) != int'(odd));
    end
    return r;
  endfunction

  function automatic logic ref_ok(input logic [BW-1:0] w, input logic odd);
    for (int k = 0; k < LANES; k++)
      if (($countones(w[k*LW +: LW]) % 2) != int'(odd)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [BW-1:0] rnd36();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [BW-1:0] corrupt(input logic [BW-1:0] w, input logic [3:0] mask, input int flips);
    logic [BW-1:0] r = w;
    for (int k = 0; k < LANES; k++)
      if (mask[k])
        for (int f = 0; f < flips; f++) r[k*LW + $urandom_range(0, LW-1)] ^= 1'b1;
    return r;
  endfunction

  task automatic cmp(input string req, input string what, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // Inputs are already set (after a falling edge); check comb outputs, then the register.
  task automatic step(input string req_err, input string req_q);
    logic mgr;
    logic [BW-1:0] nxt;
    #2;
    mgr = !cs_n && en && !wr_rd && mbx_sel && gen_en;
    cmp(mgr ? "R4" : req_err, "par_err_n", {35'd0, par_err_n}, {35'd0, (mgr ? 1'b1 : ref_ok(bus_in, odd_sel))});
    cmp("R5", "mbx_out", mbx_out, mgr ? ref_gen(mbx_word, odd_sel) : mbx_word);
    nxt = rst ? '0 : (fifo_rd_en ? (gen_en ? ref_gen(fifo_rd_word, odd_sel) : fifo_rd_word) : model_q);
    @(posedge clk);
    #2;
    model_q = nxt;
    cmp(req_q, "fifo_q", fifo_q, model_q);
  endtask

  task automatic idle_ctrl();
    cs_n = 1'b1; en = 1'b0; wr_rd = 1'b0; mbx_sel = 1'b0; gen_en = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    @(negedge clk); rst = 1'b1; fifo_rd_en = 1'b1; fifo_rd_word = rnd36(); step("R3", "R8");
    @(negedge clk); step("R3", "R8");
    @(negedge clk); rst = 1'b0; fifo_rd_en = 1'b0;

    // R1 R2: clean words in both senses, FIFO reads with generation (R6)
    for (int o = 0; o < 2; o++)
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        odd_sel = o[0]; idle_ctrl(); gen_en = 1'b1;
        bus_in = ref_gen(rnd36(), o[0]);
        fifo_rd_en = 1'b1; fifo_rd_word = rnd36();
        step("R2", "R6");
      end

    // R3: single and multi-bit corruption per lane, both senses
    for (int o = 0; o < 2; o++)
      for (int k = 0; k < LANES; k++)
        for (int f = 1; f <= 3; f++)
          for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            odd_sel = o[0]; idle_ctrl();
            bus_in = corrupt(ref_gen(rnd36(), o[0]), 4'(1 << k), f);
            fifo_rd_en = $urandom_range(0, 1); fifo_rd_word = rnd36(); gen_en = $urandom_range(0, 1);
            step("R3", "R6");
          end

    // R3: several lanes corrupted at once
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      odd_sel = $urandom_range(0, 1); idle_ctrl();
      bus_in = corrupt(ref_gen(rnd36(), odd_sel), 4'($urandom_range(1, 15)), $urandom_range(1, 2));
      step("R3", "R7");
    end

    // R4 R5: mailbox generate-read with bad bus and bad mailbox parity
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      odd_sel = i[0]; cs_n = 1'b0; en = 1'b1; wr_rd = 1'b0; mbx_sel = 1'b1; gen_en = 1'b1;
      bus_in = corrupt(ref_gen(rnd36(), odd_sel), 4'hF, 1);
      mbx_word = rnd36();
      step("R4", "R7");
    end

    // R9: generation requested but no mailbox read, checking stays live
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      odd_sel = i[0]; idle_ctrl(); gen_en = 1'b1; mbx_sel = 1'b1;
      cs_n = i[1]; en = !i[1]; wr_rd = i[2] | !i[1];
      bus_in = corrupt(ref_gen(rnd36(), odd_sel), 4'(1 << (i % 4)), 1);
      mbx_word = rnd36();
      step("R9", "R7");
    end

    // R7: register holds while read word and controls toggle
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      idle_ctrl(); gen_en = i[0]; odd_sel = i[1];
      fifo_rd_en = 1'b0; fifo_rd_word = rnd36(); bus_in = rnd36();
      step("R3", "R7");
    end

    // R8: reset overrides a read, then a raw read (R6, gen off)
    @(negedge clk); rst = 1'b1; fifo_rd_en = 1'b1; fifo_rd_word = rnd36(); step("R3", "R8");
    @(negedge clk); rst = 1'b0; gen_en = 1'b0; fifo_rd_word = rnd36(); step("R3", "R6");

    // Mixed random traffic
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      odd_sel = $urandom_range(0, 1);
      cs_n = $urandom_range(0, 1); en = $urandom_range(0, 1); wr_rd = $urandom_range(0, 1);
      mbx_sel = $urandom_range(0, 1); gen_en = $urandom_range(0, 1);
      bus_in = ($urandom_range(0, 1) == 1) ? ref_gen(rnd36(), odd_sel) : rnd36();
      mbx_word = rnd36();
      fifo_rd_en = $urandom_range(0, 1); fifo_rd_word = rnd36();
      step("R3", "R6");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule